// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter built from 4-bit slices. Each slice can be preset in parallel, advances only when two separate count enables are both high, and drives a look-ahead carry. The carry of each slice feeds the carry-side enable of the next more significant slice. The top module chains a parameter-chosen number of slices into one counter of 4 × N bits. All slices share one clock.

A parameter picks the reset style. In asynchronous mode an active-low reset clears the count at once, without waiting for a clock. In synchronous mode the clear happens on the next rising edge. Synchronous mode lets the user decode a count value and feed it back into reset, which gives a modulo-M counter whose output never shows the decoded state for less than a full clock period.

Of the two enables, only the carry-side enable (`en_t`) also gates the carry output. The other enable (`en_p`) only permits counting.

Top module: `cnt_cascade`

## Requirements
- R1: With SYNC_RESET = 0, a low `rst_n` forces `count` to zero immediately, before the next rising clock edge, and keeps it at zero while `rst_n` stays low.
- R2: With SYNC_RESET = 1, a low `rst_n` leaves `count` unchanged until the next rising edge, and that edge sets `count` to zero.
- R3: When `load_n` is low and reset is inactive, the next rising edge copies `preset` to `count` whatever the enables are. `preset[0]` is the least significant bit.
- R4: When `load_n`, `en_p` and `en_t` are all high and reset is inactive, each rising edge increments `count` by one.
- R5: An enabled count at the all-ones value wraps to zero on the next edge.
- R6: With `load_n` high and either enable low, `count` holds its value across the edge.
- R7: `carry_out` equals `en_t` AND (`count` is all ones). It does not depend on `en_p` or `load_n`, and it follows `en_t` without waiting for a clock.
- R8: The actions rank as follows: reset first, then load, then count, then hold.
- R9: Slice k+1 advances only on an edge where every lower slice is all ones and counting is enabled. The 4 × NUM_SLICES-bit output therefore behaves as one binary counter.
- R10: With SYNC_RESET = 1, driving `rst_n` low whenever `count` equals M−1 gives the repeating sequence 0 … M−1. No other value ever appears on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous depending on SYNC_RESET |
| load_n | input | 1 | Active-low parallel preset |
| preset | input | 4×NUM_SLICES | Value loaded while `load_n` is low; bit 0 is the LSB |
| en_p | input | 1 | Count enable shared by all slices; has no effect on the carry |
| en_t | input | 1 | Count enable that also gates the carry; drives the lowest slice |
| count | output | 4×NUM_SLICES | Current count value |
| carry_out | output | 1 | High while `en_t` is high and `count` is all ones |

## Verification
The clocked properties assume that the control inputs change only between rising edges, so the value they sample at an edge is the one that decided that edge. The asynchronous-clear property also assumes that `rst_n` stays low up to the following edge once it has fallen. The stimulus changes every input on the falling clock edge and holds it for a whole period. The modulo feedback is a combinational decode of `count` itself, and it changes only as the count does. Mid-cycle checks of the reset timing are taken one nanosecond after the falling edge, well clear of the next rising edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef struct packed {
        nib_t val;
    } slice_reg_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_t;

endpackage

// File: rtl/cnt_slice_next.sv
// Next-value and carry logic for one 4-bit slice.
module cnt_slice_next
    import cnt_pkg::*;
(
    input  nib_t cur,
    input  logic clr,
    input  logic load_n,
    input  nib_t preset,
    input  logic en_p,
    input  logic en_t,
    output nib_t nxt,
    output logic carry
);

    slice_op_t op;

    // Ranking: clear, then load, then count, then hold.
    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = cur + 1'b1;
            default:  nxt = cur;
        endcase
    end

    // Look-ahead carry: en_t gates it; en_p and load_n do not.
    assign carry = en_t & (&cur);

endmodule

// File: rtl/cnt_slice.sv
// One 4-bit counter slice; the reset style is chosen at elaboration.
module cnt_slice
    import cnt_pkg::*;
#(
    parameter bit SYNC_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    input  nib_t preset,
    input  logic en_p,
    input  logic en_t,
    output nib_t q,
    output logic carry
);

    slice_reg_t st_q;
    slice_reg_t st_d;
    nib_t       nxt_val;
    logic       sync_clr;

    assign sync_clr = SYNC_RESET ? !rst_n : 1'b0;

    cnt_slice_next u_next (
        .cur    (st_q.val),
        .clr    (sync_clr),
        .load_n (load_n),
        .preset (preset),
        .en_p   (en_p),
        .en_t   (en_t),
        .nxt    (nxt_val),
        .carry  (carry)
    );

    always_comb begin
        st_d     = st_q;
        st_d.val = nxt_val;
    end

    generate
        if (SYNC_RESET) begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end else begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    assign q = st_q.val;

endmodule

// File: rtl/cnt_cascade.sv
// Chain of NUM_SLICES slices; each carry feeds the next slice's en_t.
module cnt_cascade
    import cnt_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    parameter bit SYNC_RESET = 1'b1,
    localparam int W = NUM_SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] preset,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] count,
    output logic         carry_out
);

    logic [NUM_SLICES:0] chain;

    assign chain[0] = en_t;

    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
            cnt_slice #(
                .SYNC_RESET (SYNC_RESET)
            ) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_n (load_n),
                .preset (preset[k*SLICE_W +: SLICE_W]),
                .en_p   (en_p),
                .en_t   (chain[k]),
                .q      (count[k*SLICE_W +: SLICE_W]),
                .carry  (chain[k+1])
            );
        end
    endgenerate

    assign carry_out = chain[NUM_SLICES];

endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk #(
    parameter int W          = 8,
    parameter bit SYNC_RESET = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic [W-1:0] preset,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] count,
    input logic         carry_out
);

    generate
        if (SYNC_RESET) begin : g_sync_chk
            // R2: a clear sampled at an edge yields zero after it
            a_r2_sync_clear: assert property (@(posedge clk)
                !rst_n |=> (count == '0));
        end else begin : g_async_chk
            // R1: while reset is low the count reads zero
            a_r1_async_clear: assert property (@(posedge clk)
                !rst_n |-> (count == '0));
        end
        if (W > 4) begin : g_casc_chk
            // R9: upper slices wait for an all-ones low nibble
            a_r9_upper_waits: assert property (@(posedge clk) disable iff (!rst_n)
                (load_n && en_p && en_t && count[3:0] != 4'hF)
                |=> (count[W-1:4] == $past(count[W-1:4])));
        end
    endgenerate

    // R3 / R8: load beats counting
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (count == $past(preset)));

    // R4 / R5: enabled count advances by one modulo 2^W
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t) |=> (count == $past(count) + 1'b1));

    // R6: either enable low holds the value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_p && en_t)) |=> $stable(count));

    // R7: carry tracks en_t and all-ones count
    a_r7_carry: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == (en_t && (&count)));

endmodule

bind cnt_cascade cnt_cascade_chk #(
    .W          (W),
    .SYNC_RESET (SYNC_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .preset    (preset),
    .en_p      (en_p),
    .en_t      (en_t),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/tb_cnt_cascade.sv
`timescale 1ns/1ps
module tb_cnt_cascade;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_s_n, rst_a_n, load_n, en_p, en_t, mod_on;
    logic [7:0] preset, mod_last;
    logic [7:0] cnt_s;
    logic       car_s;
    logic [3:0] cnt_a;
    logic       car_a;
    logic       dut_rst_n;

    // R10 feedback: decode of the count drives the synchronous clear
    assign dut_rst_n = rst_s_n & ~(mod_on && (cnt_s == mod_last));

    cnt_cascade #(.NUM_SLICES(2), .SYNC_RESET(1'b1)) dut (
        .clk(clk), .rst_n(dut_rst_n), .load_n(load_n), .preset(preset),
        .en_p(en_p), .en_t(en_t), .count(cnt_s), .carry_out(car_s));

    cnt_cascade #(.NUM_SLICES(1), .SYNC_RESET(1'b0)) dut_a (
        .clk(clk), .rst_n(rst_a_n), .load_n(load_n), .preset(preset[3:0]),
        .en_p(en_p), .en_t(en_t), .count(cnt_a), .carry_out(car_a));

    typedef struct {
        string      tag;
        logic [7:0] s;
        logic       cs;
        logic [3:0] a;
        logic       ca;
    } exp_t;

    exp_t       sb[$];
    int         total = 0;
    int         bad = 0;
    logic [7:0] m_s = '0;
    logic [3:0] m_a = '0;
    logic       done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies inputs at the falling edge, advances the model, queues the result
    task automatic drive(input logic rs, input logic ra, input logic ld,
                         input logic [7:0] p, input logic ep, input logic et,
                         input string tag);
        exp_t e;
        logic rst_eff;
        @(negedge clk);
        rst_s_n = rs; rst_a_n = ra; load_n = ld; preset = p; en_p = ep; en_t = et;
        rst_eff = rs && !(mod_on && (m_s == mod_last));
        if (!rst_eff)       m_s = '0;
        else if (!ld)       m_s = p;
        else if (ep && et)  m_s = m_s + 8'd1;
        if (!ra)            m_a = '0;
        else if (!ld)       m_a = p[3:0];
        else if (ep && et)  m_a = m_a + 4'd1;
        e.tag = tag;
        e.s   = m_s;
        e.cs  = et && (m_s == 8'hFF);
        e.a   = m_a;
        e.ca  = et && (m_a == 4'hF);
        sb.push_back(e);
    endtask

    // Monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "sync count",  {24'd0, cnt_s}, {24'd0, e.s});
                chk(e.tag, "sync carry",  {31'd0, car_s}, {31'd0, e.cs});
                chk(e.tag, "async count", {28'd0, cnt_a}, {28'd0, e.a});
                chk(e.tag, "async carry", {31'd0, car_a}, {31'd0, e.ca});
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_s_n = 1'b0; rst_a_n = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
        preset = '0; mod_on = 1'b0; mod_last = '0;
        #1 rst_a_n = 1'b0;

        // Reset state, both styles (R1, R2)
        drive(0, 0, 1, 8'h00, 1, 1, "R1 R2 reset");
        drive(0, 0, 1, 8'h00, 1, 1, "R1 R2 reset");

        // Preset to twelve, count through the wrap, then inhibit (R3 R4 R5 R7)
        drive(1, 1, 0, 8'h0C, 1, 1, "R3 preset 12");
        drive(1, 1, 1, 8'h00, 1, 1, "R4 count 13");
        drive(1, 1, 1, 8'h00, 1, 1, "R4 count 14");
        drive(1, 1, 1, 8'h00, 1, 1, "R7 count 15 carry");
        drive(1, 1, 1, 8'h00, 1, 1, "R5 wrap 0");
        drive(1, 1, 1, 8'h00, 1, 1, "R4 count 1");
        drive(1, 1, 1, 8'h00, 1, 1, "R4 count 2");
        drive(1, 1, 1, 8'h00, 0, 1, "R6 inhibit en_p");
        drive(1, 1, 1, 8'h00, 1, 0, "R6 inhibit en_t");

        // Carry ignores en_p and load_n, follows en_t (R7)
        drive(1, 1, 0, 8'hFF, 0, 1, "R3 load ff");
        drive(1, 1, 1, 8'h00, 0, 1, "R7 carry with en_p low");
        drive(1, 1, 0, 8'hFF, 0, 1, "R7 carry with load low");
        drive(1, 1, 1, 8'h00, 1, 0, "R7 no carry en_t low");
        drive(1, 1, 1, 8'h00, 1, 1, "R5 wrap ff");

        // Load beats counting, reset beats load (R3 R8)
        drive(1, 1, 0, 8'hA5, 1, 1, "R3 R8 load over count");
        drive(0, 0, 0, 8'h3C, 1, 1, "R8 reset over load");
        drive(1, 1, 0, 8'h5A, 1, 1, "R3 bit order");

        // Cascade ripple (R9)
        drive(1, 1, 0, 8'h0E, 1, 1, "R9 load 0e");
        drive(1, 1, 1, 8'h00, 1, 1, "R9 count 0f");
        drive(1, 1, 1, 8'h00, 1, 1, "R9 carry into upper");
        drive(1, 1, 0, 8'h1F, 1, 1, "R9 load 1f");
        drive(1, 1, 1, 8'h00, 1, 0, "R9 en_t low holds upper");
        drive(1, 1, 0, 8'hFE, 1, 1, "R9 load fe");
        drive(1, 1, 1, 8'h00, 1, 1, "R9 ff carry");
        drive(1, 1, 1, 8'h00, 1, 1, "R9 R5 full wrap");

        // Synchronous reset waits for the edge (R2)
        drive(1, 1, 0, 8'h39, 1, 1, "R3 load 39");
        drive(0, 1, 1, 8'h00, 0, 0, "R2 sync clear");
        #1;
        chk("R2", "count before edge", {24'd0, cnt_s}, 32'h39);

        // Asynchronous reset acts mid-cycle (R1)
        drive(1, 1, 0, 8'h09, 1, 1, "R3 load 09");
        drive(1, 0, 1, 8'h00, 0, 0, "R1 async clear");
        #1;
        chk("R1", "count before edge", {28'd0, cnt_a}, 32'h0);
        drive(1, 0, 1, 8'h00, 1, 1, "R1 held low");

        // Modulo-5 by decoded synchronous clear (R10)
        drive(0, 1, 1, 8'h00, 1, 1, "R10 mod5 reset");
        mod_on = 1'b1;
        mod_last = 8'd4;
        for (int i = 0; i < 12; i++) drive(1, 1, 1, 8'h00, 1, 1, "R10 mod5");

        // Modulo-11 (R10)
        drive(0, 1, 1, 8'h00, 1, 1, "R10 mod11 reset");
        mod_last = 8'd10;
        for (int i = 0; i < 25; i++) drive(1, 1, 1, 8'h00, 1, 1, "R10 mod11");

        drive(0, 1, 1, 8'h00, 0, 0, "R2 final reset");
        mod_on = 1'b0;
        while (sb.size() > 0) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule